// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where instruction fetch goes next. It takes the current program counter, a decoded control-flow code, the 16-bit branch offset, the 26-bit jump field and the two source register values. From these it produces the next program counter, a flag that says whether the flow was redirected, and a request to write a return address into the link register.

It handles six kinds of control flow:
- equality and inequality branches between two registers;
- signed tests of one register against zero;
- two of those zero tests that also save a return address;
- direct jumps that keep the upper bits of the sequential address;
- jump-and-link;
- jumps through a register.

All outputs are registered. A result appears on the clock edge that follows the cycle in which its inputs were presented. The surrounding pipeline therefore sees one cycle of latency and a clean timing boundary.

Top module: `bnpc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become zero: `next_pc_o`, `taken_o`, `link_en_o` and `link_val_o`. `link_reg_o` always reads 31. Otherwise, each output at an edge reflects the inputs that were present at that edge, and is visible from that edge until the next one.
- R2: Code 0 means no flow change, and codes 12 to 15 behave the same way. For these codes `taken_o` is 0, `link_en_o` is 0 and `next_pc_o` is `pc_i + 4`. Any branch whose condition fails also gives `taken_o` = 0 and `next_pc_o` = `pc_i + 4`.
- R3: Code 1 branches when `rs_i == rt_i`, and code 2 branches when they differ. The branch target is `pc_i + 4 + (sign-extended offset << 2)`.
- R4: Codes 3 to 6 treat `rs_i` as two's complement and branch to the same kind of target as R3. The conditions are:
  - code 3: `rs_i <= 0`
  - code 4: `rs_i > 0`
  - code 5: `rs_i < 0`
  - code 6: `rs_i >= 0`
- R5: Code 7 branches when `rs_i < 0`, and code 8 branches when `rs_i >= 0`. Both always set `link_en_o` = 1 with `link_val_o` = `pc_i + 4`, whether or not the branch is taken.
- R6: Code 9 is a direct jump. `taken_o` is 1 and `next_pc_o` = {upper 4 bits of `pc_i + 4`, `jfield_i`, 2'b00}.
- R7: Code 10 jumps to the same target as R6. It also sets `link_en_o` = 1 with `link_val_o` = `pc_i + 4`.
- R8: Code 11 sets `taken_o` = 1 and `next_pc_o` = `rs_i`, unchanged.
- R9: `link_en_o` is 1 only for codes 7, 8 and 10. When it is 0, `link_val_o` is 0.
- R10: All address sums wrap modulo 2^32. A backward offset can move the target below `pc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Control-flow code (see requirements) |
| pc_i | input | 32 | Address of the current instruction |
| off_i | input | 16 | Branch word offset |
| jfield_i | input | 26 | Direct jump field |
| rs_i | input | 32 | First source register value |
| rt_i | input | 32 | Second source register value |
| next_pc_o | output | 32 | Registered next fetch address |
| taken_o | output | 1 | Registered redirect flag |
| link_en_o | output | 1 | Registered link-register write request |
| link_reg_o | output | 5 | Link register index (31) |
| link_val_o | output | 32 | Registered return address |

## Verification
The bench builds the block with its default widths: a 32-bit address, a 16-bit offset and a 26-bit jump field. Directed cases place `pc_i` at 0xFFFFFFFC so that the sequential and branch sums wrap. A PC in the last word of a 256 MB region shows that the jump's upper bits come from `pc_i + 4` and not from `pc_i`. Offsets of 0x8000 and 0x7FFF exercise the sign extension at its limits. Register values of 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF sit on every edge of the zero tests. Random codes cover the unused codes 12 to 15, and random `rs_i`/`rt_i` are biased toward zero and toward equality.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;
  typedef enum logic [3:0] {
    FLOW_NONE   = 4'd0,
    FLOW_EQ     = 4'd1,
    FLOW_NE     = 4'd2,
    FLOW_LEZ    = 4'd3,
    FLOW_GTZ    = 4'd4,
    FLOW_LTZ    = 4'd5,
    FLOW_GEZ    = 4'd6,
    FLOW_LTZ_LK = 4'd7,
    FLOW_GEZ_LK = 4'd8,
    FLOW_JMP    = 4'd9,
    FLOW_JMP_LK = 4'd10,
    FLOW_JREG   = 4'd11
  } flow_op_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/bnpc_cond.sv
module bnpc_cond
  import bnpc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  output logic              take,
  output logic              link,
  output logic              via_reg,
  output logic              via_field
);
  logic is_neg;
  logic is_zero;
  logic is_same;
  flow_op_e kind;

  always_comb begin
    kind    = flow_op_e'(op);
    is_neg  = rs_val[DATA_W-1];
    is_zero = (rs_val == '0);
    is_same = (rs_val == rt_val);
  end

  always_comb begin
    take      = 1'b0;
    link      = 1'b0;
    via_reg   = 1'b0;
    via_field = 1'b0;
    case (kind)
      FLOW_EQ:     take = is_same;
      FLOW_NE:     take = !is_same;
      FLOW_LEZ:    take = is_neg || is_zero;
      FLOW_GTZ:    take = !is_neg && !is_zero;
      FLOW_LTZ:    take = is_neg;
      FLOW_GEZ:    take = !is_neg;
      FLOW_LTZ_LK: begin take = is_neg;  link = 1'b1; end
      FLOW_GEZ_LK: begin take = !is_neg; link = 1'b1; end
      FLOW_JMP:    begin take = 1'b1; via_field = 1'b1; end
      FLOW_JMP_LK: begin take = 1'b1; via_field = 1'b1; link = 1'b1; end
      FLOW_JREG:   begin take = 1'b1; via_reg = 1'b1; end
      default:     take = 1'b0;
    endcase
  end
endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
  import bnpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned JF_W   = 26
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  offset,
  input  logic [JF_W-1:0]   jfield,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] rel_pc,
  output logic [ADDR_W-1:0] abs_pc
);
  localparam int unsigned SHIFT  = $clog2(INSN_BYTES);
  localparam int unsigned EXT_W  = ADDR_W - OFF_W - SHIFT;
  localparam int unsigned KEEP_W = ADDR_W - JF_W - SHIFT;

  logic [ADDR_W-1:0] disp;

  always_comb begin
    seq_pc = pc + ADDR_W'(INSN_BYTES);
    disp   = {{EXT_W{offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
    rel_pc = seq_pc + disp;
    abs_pc = {seq_pc[ADDR_W-1 -: KEEP_W], jfield, {SHIFT{1'b0}}};
  end
endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
  import bnpc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned JF_W      = 26,
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned LINK_IDX  = 31
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           op_i,
  input  logic [ADDR_W-1:0]    pc_i,
  input  logic [OFF_W-1:0]     off_i,
  input  logic [JF_W-1:0]      jfield_i,
  input  logic [ADDR_W-1:0]    rs_i,
  input  logic [ADDR_W-1:0]    rt_i,
  output logic [ADDR_W-1:0]    next_pc_o,
  output logic                 taken_o,
  output logic                 link_en_o,
  output logic [REG_IDX_W-1:0] link_reg_o,
  output logic [ADDR_W-1:0]    link_val_o
);
  logic              take;
  logic              link;
  logic              via_reg;
  logic              via_field;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] rel_pc;
  logic [ADDR_W-1:0] abs_pc;
  logic [ADDR_W-1:0] nxt_d;
  logic [ADDR_W-1:0] lnk_d;

  bnpc_cond #(.DATA_W(ADDR_W)) u_cond (
    .op        (op_i),
    .rs_val    (rs_i),
    .rt_val    (rt_i),
    .take      (take),
    .link      (link),
    .via_reg   (via_reg),
    .via_field (via_field)
  );

  bnpc_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .JF_W(JF_W)) u_tgt (
    .pc     (pc_i),
    .offset (off_i),
    .jfield (jfield_i),
    .seq_pc (seq_pc),
    .rel_pc (rel_pc),
    .abs_pc (abs_pc)
  );

  always_comb begin
    if (!take)          nxt_d = seq_pc;
    else if (via_reg)   nxt_d = rs_i;
    else if (via_field) nxt_d = abs_pc;
    else                nxt_d = rel_pc;
    lnk_d = link ? seq_pc : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc_o  <= '0;
      taken_o    <= 1'b0;
      link_en_o  <= 1'b0;
      link_val_o <= '0;
    end else begin
      next_pc_o  <= nxt_d;
      taken_o    <= take;
      link_en_o  <= link;
      link_val_o <= lnk_d;
    end
  end

  assign link_reg_o = REG_IDX_W'(LINK_IDX);
endmodule

// File: rtl/bnpc_unit_chk.sv
module bnpc_unit_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] rs_i,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic              taken_o,
  input logic              link_en_o,
  input logic [ADDR_W-1:0] link_val_o
);
  AST_UNTAKEN_FALLS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !taken_o) |-> (next_pc_o == $past(pc_i) + ADDR_W'(4))); // R2

  AST_LINK_RETURN_ADDR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && link_en_o) |-> (link_val_o == $past(pc_i) + ADDR_W'(4))); // R5

  AST_LINK_ONLY_LINKERS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && link_en_o) |->
      ($past(op_i) == 4'd7 || $past(op_i) == 4'd8 || $past(op_i) == 4'd10)); // R9

  AST_NO_LINK_VALUE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !link_en_o |-> (link_val_o == '0)); // R9

  AST_JREG_TARGET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 4'd11) |-> (taken_o && next_pc_o == $past(rs_i))); // R8

  AST_JUMPS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == 4'd9 || $past(op_i) == 4'd10)) |-> taken_o); // R6

  AST_JAL_LINKS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == 4'd10) |-> link_en_o); // R7

  AST_UNUSED_CODES_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == 4'd0 || $past(op_i) >= 4'd12)) |->
      (!taken_o && !link_en_o)); // R2
endmodule

bind bnpc_unit bnpc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_i       (op_i),
  .pc_i       (pc_i),
  .rs_i       (rs_i),
  .next_pc_o  (next_pc_o),
  .taken_o    (taken_o),
  .link_en_o  (link_en_o),
  .link_val_o (link_val_o)
);

// File: tb/test_bnpc_unit.sv
`timescale 1ns/1ps
module test_bnpc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [31:0] pc_i = '0;
  logic [15:0] off_i = '0;
  logic [25:0] jfield_i = '0;
  logic [31:0] rs_i = '0;
  logic [31:0] rt_i = '0;
  logic [31:0] next_pc_o;
  logic        taken_o;
  logic        link_en_o;
  logic [4:0]  link_reg_o;
  logic [31:0] link_val_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bnpc_unit i_bnpc_unit (
    .clk(clk), .rst(rst), .op_i(op_i), .pc_i(pc_i), .off_i(off_i),
    .jfield_i(jfield_i), .rs_i(rs_i), .rt_i(rt_i), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .link_en_o(link_en_o), .link_reg_o(link_reg_o),
    .link_val_o(link_val_o)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd1, 4'd2:   return "R3";
      4'd3, 4'd4, 4'd5, 4'd6: return "R4";
      4'd7, 4'd8:   return "R5";
      4'd9:         return "R6";
      4'd10:        return "R7";
      4'd11:        return "R8";
      default:      return "R2";
    endcase
  endfunction

  function automatic bit exp_take(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      4'd1: return a == b;
      4'd2: return a != b;
      4'd3: return $signed(a) <= 0;
      4'd4: return $signed(a) > 0;
      4'd5, 4'd7: return $signed(a) < 0;
      4'd6, 4'd8: return $signed(a) >= 0;
      4'd9, 4'd10, 4'd11: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_next(input logic [3:0] op, input logic [31:0] pc,
      input logic [15:0] off, input logic [25:0] jf, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] seq;
    seq = pc + 32'd4;
    if (!exp_take(op, a, b)) return seq;
    if (op == 4'd11) return a;
    if (op == 4'd9 || op == 4'd10) return {seq[31:28], jf, 2'b00};
    return seq + {{14{off[15]}}, off, 2'b00};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] pc, input logic [15:0] off,
      input logic [25:0] jf, input logic [31:0] a, input logic [31:0] b);
    logic lk;
    @(negedge clk);
    op_i = op; pc_i = pc; off_i = off; jfield_i = jf; rs_i = a; rt_i = b;
    @(negedge clk);
    lk = (op == 4'd7 || op == 4'd8 || op == 4'd10);
    check(req_of(op), "next_pc", next_pc_o, exp_next(op, pc, off, jf, a, b));
    check(req_of(op), "taken", {31'd0, taken_o}, {31'd0, exp_take(op, a, b)});
    check("R9", "link_en", {31'd0, link_en_o}, {31'd0, lk});
    check(lk ? "R5" : "R9", "link_val", link_val_o, lk ? pc + 32'd4 : 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    op_i = 4'd10; pc_i = 32'h1234_5678; rs_i = 32'h5;
    repeat (3) @(negedge clk);
    check("R1", "reset next_pc", next_pc_o, 32'd0);
    check("R1", "reset taken", {31'd0, taken_o}, 32'd0);
    check("R1", "reset link_en", {31'd0, link_en_o}, 32'd0);
    check("R1", "reset link_val", link_val_o, 32'd0);
    check("R9", "link_reg", {27'd0, link_reg_o}, 32'd31);
    rst = 1'b0;

    apply(4'd0, 32'h0000_1000, 16'h0010, 26'h1, 32'd0, 32'd0);          // R2
    apply(4'd13, 32'h0000_2000, 16'h0010, 26'h1, 32'd0, 32'd0);         // R2
    apply(4'd1, 32'h0000_1000, 16'h7FFF, '0, 32'd7, 32'd7);             // R3
    apply(4'd1, 32'h0000_1000, 16'h8000, '0, 32'd7, 32'd8);             // R3 untaken
    apply(4'd2, 32'h0040_0000, 16'hFFFF, '0, 32'd7, 32'd8);             // R3 backward
    apply(4'd3, 32'h100, 16'h4, '0, 32'd0, 32'd0);                      // R4
    apply(4'd4, 32'h100, 16'h4, '0, 32'd0, 32'd0);                      // R4
    apply(4'd4, 32'h100, 16'h4, '0, 32'h7FFF_FFFF, 32'd0);              // R4
    apply(4'd5, 32'h100, 16'h4, '0, 32'h8000_0000, 32'd0);              // R4
    apply(4'd6, 32'h100, 16'h4, '0, 32'hFFFF_FFFF, 32'd0);              // R4
    apply(4'd7, 32'h200, 16'h8, '0, 32'd1, 32'd0);                      // R5 untaken links
    apply(4'd8, 32'h200, 16'h8, '0, 32'd0, 32'd0);                      // R5
    apply(4'd9, 32'h0FFF_FFFC, '0, 26'h3FF_FFFF, 32'd0, 32'd0);         // R6 region edge
    apply(4'd10, 32'hA000_0040, '0, 26'h000_0123, 32'd0, 32'd0);        // R7
    apply(4'd11, 32'h300, '0, '0, 32'hDEAD_BEEF, 32'd0);                // R8
    apply(4'd0, 32'hFFFF_FFFC, '0, '0, 32'd0, 32'd0);                   // R10 wrap
    apply(4'd1, 32'hFFFF_FFFC, 16'h0002, '0, 32'd3, 32'd3);             // R10 wrap
    apply(4'd2, 32'h0000_0004, 16'h8000, '0, 32'd3, 32'd4);             // R10 underflow

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = $urandom();
      case ($urandom_range(0, 3))
        0: a = 32'd0;
        1: a = {$urandom_range(0, 1) == 1 ? 1'b1 : 1'b0, 31'd0} | 32'($urandom_range(0, 3));
        default: ;
      endcase
      b = ($urandom_range(0, 3) == 0) ? a : $urandom();
      apply(4'($urandom_range(0, 15)), $urandom() & 32'hFFFF_FFFC,
            16'($urandom()), 26'($urandom()), a, b);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule